// File: doc/BRIEF.md
# Total-Store-Order Write Buffer

This block sits between the commit stage of an in-order core and a single-ported memory. Each committed store is parked in a small queue and written to memory later, one entry per granted request, oldest first. A load does not wait for those writes. If the load address matches a queued store, the youngest matching store supplies the data at once. Otherwise the load reads memory and, when both want the port, the load goes first.

Two operations restore order when software needs it. A write-to-read fence completes only after every store queued ahead of it has been written to memory. An atomic swap also waits for the queue to empty. It then issues a single indivisible swap transaction and returns the old memory word. While a fence or swap is pending, no new stores are taken in. The core presents at most one of load, fence and swap at a time, and holds each request until its done pulse. If more than one is raised, the order of precedence is fence, then swap, then load.

The controller has five states:
- `S_IDLE` serves loads and drains the queue. It moves to `S_FENCE_DRAIN` on a fence, to `S_AMO_DRAIN` on a swap, and to `S_LD_WAIT` when a memory read is granted.
- `S_LD_WAIT` returns to `S_IDLE` on the read response.
- `S_FENCE_DRAIN` returns to `S_IDLE` once the queue is empty, pulsing `fence_done`.
- `S_AMO_DRAIN` moves to `S_AMO_WAIT` when its swap is granted on an empty queue.
- `S_AMO_WAIT` returns to `S_IDLE` on the response, pulsing `amo_done`.

Top module: `tso_wbuf`

## Requirements
- R1: In `S_IDLE` or `S_LD_WAIT`, while fewer than DEPTH stores are queued, `st_ready` is high, and a store is taken in on a cycle with `st_valid` and `st_ready` both high.
- R2: With DEPTH stores queued, `st_ready` is low.
- R3: Queued stores reach memory as write requests (`mem_op` = 1) in exactly the order they were taken in. Each write completes on the cycle `mem_gnt` is high, with no response. After a final fence, memory holds the program-order value of every word.
- R4: A load whose address matches a queued store completes in the same cycle it is presented (`ld_done`), returning the youngest matching store's data, and issues no memory read.
- R5: A load with no match issues a read (`mem_op` = 0), which takes the port ahead of queued stores. The load returns `mem_rdata` with `ld_done` in the cycle `mem_rvalid` is high, even while older stores are still queued.
- R6: `fence_done` pulses for exactly one cycle, only after every store taken in before the fence has been written to memory. `st_ready` stays low while the fence is pending.
- R7: A swap (`mem_op` = 2) is issued only when the queue is empty. It writes `amo_wdata`, and `amo_done` returns the prior memory word in `amo_rdata`.
- R8: `buffer_empty` is high exactly when no store is queued, and no write request is made while it is high.
- R9: After reset the queue is empty, `st_ready` is high, and `mem_req`, `fence_done` and `amo_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Committed store present |
| st_ready | output | 1 | Store can be taken in |
| st_addr | input | AW | Store word address |
| st_data | input | DW | Store data |
| ld_valid | input | 1 | Load request, held until `ld_done` |
| ld_addr | input | AW | Load word address |
| ld_done | output | 1 | Load complete, data valid |
| ld_rdata | output | DW | Load result |
| fence_req | input | 1 | Write-to-read fence, held until `fence_done` |
| fence_done | output | 1 | One-cycle fence completion pulse |
| amo_valid | input | 1 | Atomic swap request, held until `amo_done` |
| amo_addr | input | AW | Swap address |
| amo_wdata | input | DW | Value written by the swap |
| amo_done | output | 1 | Swap complete |
| amo_rdata | output | DW | Memory word before the swap |
| buffer_empty | output | 1 | No stores queued |
| mem_req | output | 1 | Memory request valid |
| mem_op | output | 2 | 0 read, 1 write, 2 swap |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_gnt | input | 1 | Memory accepts the request this cycle |
| mem_rvalid | input | 1 | Read or swap response valid |
| mem_rdata | input | DW | Read or swap response data |

## Verification
The bench builds the block with DEPTH = 4, AW = 4 and DW = 16. The shallow queue fills after four stores, so the full condition can be reached quickly. The sixteen-word address space lets randomly chosen addresses collide often, which exercises forwarding from several entries that share an address. It also makes it cheap to compare the whole memory against the program-order model after the final fence, while grants are stalled in a pseudo-random pattern.

// File: rtl/tso_wbuf_pkg.sv
package tso_wbuf_pkg;

    // Memory operation encoding seen on the mem_op port.
    typedef enum logic [1:0] {
        MOP_READ  = 2'd0,
        MOP_WRITE = 2'd1,
        MOP_SWAP  = 2'd2
    } mem_op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LD_WAIT,
        S_FENCE_DRAIN,
        S_AMO_DRAIN,
        S_AMO_WAIT
    } wb_state_e;

endpackage

// File: rtl/wbuf_queue.sv
// Circular store queue with a youngest-match search for forwarding.
module wbuf_queue #(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int DW    = 32,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = PW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [AW-1:0] push_addr,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [AW-1:0] head_addr,
    output logic [DW-1:0] head_data,
    output logic [CW-1:0] occ,
    output logic          full,
    output logic          empty,
    input  logic [AW-1:0] look_addr,
    output logic          hit,
    output logic [DW-1:0] hit_data
);

    logic [AW-1:0] addr_q [DEPTH];
    logic [DW-1:0] data_q [DEPTH];
    logic [PW-1:0] rd_ptr, wr_ptr;
    logic [DEPTH-1:0] match;

    always_ff @(posedge clk) begin
        if (push) begin
            addr_q[wr_ptr] <= push_addr;
            data_q[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            occ    <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
            occ <= occ + CW'(push) - CW'(pop);
        end
    end

    // Per-entry live and address compare.
    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        logic [PW-1:0] age;
        logic          live;
        assign age      = PW'(i) - rd_ptr;
        assign live     = {1'b0, age} < occ;
        assign match[i] = live && (addr_q[i] == look_addr);
    end

    // Walk from oldest to youngest so the last match wins.
    always_comb begin
        logic [PW-1:0] idx;
        idx      = '0;
        hit      = 1'b0;
        hit_data = '0;
        for (int k = 0; k < DEPTH; k++) begin
            idx = rd_ptr + PW'(k);
            if (match[idx]) begin
                hit      = 1'b1;
                hit_data = data_q[idx];
            end
        end
    end

    assign head_addr = addr_q[rd_ptr];
    assign head_data = data_q[rd_ptr];
    assign full      = (occ == CW'(DEPTH));
    assign empty     = (occ == '0);

endmodule

// File: rtl/wbuf_ctrl.sv
// Ordering controller: arbitrates the memory port and sequences fences and swaps.
module wbuf_ctrl
    import tso_wbuf_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    st_valid,
    input  logic    ld_valid,
    input  logic    ld_hit,
    input  logic    fence_req,
    input  logic    amo_valid,
    input  logic    q_empty,
    input  logic    q_full,
    input  logic    mem_gnt,
    input  logic    mem_rvalid,
    output logic    st_ready,
    output logic    push,
    output logic    pop,
    output logic    mem_req,
    output mem_op_e mem_op,
    output logic    ld_done,
    output logic    ld_fwd,
    output logic    fence_done,
    output logic    amo_done
);

    wb_state_e state, nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: begin
                if (fence_req)                          nxt = S_FENCE_DRAIN;
                else if (amo_valid)                     nxt = S_AMO_DRAIN;
                else if (ld_valid && !ld_hit && mem_gnt) nxt = S_LD_WAIT;
            end
            S_LD_WAIT:     if (mem_rvalid)           nxt = S_IDLE;
            S_FENCE_DRAIN: if (q_empty)              nxt = S_IDLE;
            S_AMO_DRAIN:   if (q_empty && mem_gnt)   nxt = S_AMO_WAIT;
            S_AMO_WAIT:    if (mem_rvalid)           nxt = S_IDLE;
            default:                                 nxt = S_IDLE;
        endcase
    end

    always_comb begin
        logic drain;
        drain      = 1'b0;
        mem_req    = 1'b0;
        mem_op     = MOP_WRITE;
        pop        = 1'b0;
        ld_done    = 1'b0;
        ld_fwd     = 1'b0;
        fence_done = 1'b0;
        amo_done   = 1'b0;
        st_ready   = !q_full && (state == S_IDLE || state == S_LD_WAIT);
        push       = st_valid && st_ready;
        unique case (state)
            S_IDLE: begin
                if (!fence_req && !amo_valid && ld_valid && !ld_hit) begin
                    mem_req = 1'b1;
                    mem_op  = MOP_READ;
                end else begin
                    if (!fence_req && !amo_valid && ld_valid) begin
                        ld_done = 1'b1;
                        ld_fwd  = 1'b1;
                    end
                    drain = !q_empty;
                end
            end
            S_LD_WAIT: ld_done = mem_rvalid;
            S_FENCE_DRAIN: begin
                drain      = !q_empty;
                fence_done = q_empty;
            end
            S_AMO_DRAIN: begin
                if (q_empty) begin
                    mem_req = 1'b1;
                    mem_op  = MOP_SWAP;
                end else begin
                    drain = 1'b1;
                end
            end
            S_AMO_WAIT: amo_done = mem_rvalid;
            default: ;
        endcase
        if (drain) begin
            mem_req = 1'b1;
            mem_op  = MOP_WRITE;
            pop     = mem_gnt;
        end
    end

endmodule

// File: rtl/tso_wbuf.sv
module tso_wbuf
    import tso_wbuf_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int DW    = 32,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          st_valid,
    output logic          st_ready,
    input  logic [AW-1:0] st_addr,
    input  logic [DW-1:0] st_data,
    input  logic          ld_valid,
    input  logic [AW-1:0] ld_addr,
    output logic          ld_done,
    output logic [DW-1:0] ld_rdata,
    input  logic          fence_req,
    output logic          fence_done,
    input  logic          amo_valid,
    input  logic [AW-1:0] amo_addr,
    input  logic [DW-1:0] amo_wdata,
    output logic          amo_done,
    output logic [DW-1:0] amo_rdata,
    output logic          buffer_empty,
    output logic          mem_req,
    output logic [1:0]    mem_op,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_gnt,
    input  logic          mem_rvalid,
    input  logic [DW-1:0] mem_rdata
);

    logic          push, pop, q_full, q_empty, hit, ld_fwd;
    logic [AW-1:0] head_addr;
    logic [DW-1:0] head_data, hit_data;
    logic [CW-1:0] occ;
    mem_op_e       mop;

    wbuf_queue #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_addr (st_addr),
        .push_data (st_data),
        .pop       (pop),
        .head_addr (head_addr),
        .head_data (head_data),
        .occ       (occ),
        .full      (q_full),
        .empty     (q_empty),
        .look_addr (ld_addr),
        .hit       (hit),
        .hit_data  (hit_data)
    );

    wbuf_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .st_valid   (st_valid),
        .ld_valid   (ld_valid),
        .ld_hit     (hit),
        .fence_req  (fence_req),
        .amo_valid  (amo_valid),
        .q_empty    (q_empty),
        .q_full     (q_full),
        .mem_gnt    (mem_gnt),
        .mem_rvalid (mem_rvalid),
        .st_ready   (st_ready),
        .push       (push),
        .pop        (pop),
        .mem_req    (mem_req),
        .mem_op     (mop),
        .ld_done    (ld_done),
        .ld_fwd     (ld_fwd),
        .fence_done (fence_done),
        .amo_done   (amo_done)
    );

    always_comb begin
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (mop)
            MOP_WRITE: begin
                mem_addr  = head_addr;
                mem_wdata = head_data;
            end
            MOP_READ:  mem_addr = ld_addr;
            MOP_SWAP: begin
                mem_addr  = amo_addr;
                mem_wdata = amo_wdata;
            end
            default: ;
        endcase
    end

    assign mem_op       = mop;
    assign ld_rdata     = ld_fwd ? hit_data : mem_rdata;
    assign amo_rdata    = mem_rdata;
    assign buffer_empty = q_empty;

endmodule

// File: rtl/tso_wbuf_chk.sv
module tso_wbuf_chk #(
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          st_ready,
    input logic          buffer_empty,
    input logic          fence_done,
    input logic          ld_done,
    input logic          ld_fwd,
    input logic          mem_req,
    input logic [1:0]    mem_op,
    input logic [CW-1:0] q_occ
);

    assert_full_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (q_occ == CW'(DEPTH)) |-> !st_ready);

    assert_fence_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fence_done |=> !fence_done);

    assert_fence_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fence_done |-> (buffer_empty && !st_ready));

    assert_swap_after_drain_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_op == 2'd2) |-> buffer_empty);

    assert_fwd_no_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_done && ld_fwd) |-> !(mem_req && mem_op == 2'd0));

    assert_no_write_when_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        buffer_empty |-> !(mem_req && mem_op == 2'd1));

endmodule

bind tso_wbuf tso_wbuf_chk #(.DEPTH(DEPTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .st_ready     (st_ready),
    .buffer_empty (buffer_empty),
    .fence_done   (fence_done),
    .ld_done      (ld_done),
    .ld_fwd       (ld_fwd),
    .mem_req      (mem_req),
    .mem_op       (mem_op),
    .q_occ        (occ)
);

// File: tb/test_tso_wbuf.sv
module test_tso_wbuf;
    localparam int DEPTH = 4;
    localparam int AW    = 4;
    localparam int DW    = 16;
    localparam int NW    = 1 << AW;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          st_valid = 1'b0, st_ready;
    logic [AW-1:0] st_addr = '0;
    logic [DW-1:0] st_data = '0;
    logic          ld_valid = 1'b0, ld_done;
    logic [AW-1:0] ld_addr = '0;
    logic [DW-1:0] ld_rdata;
    logic          fence_req = 1'b0, fence_done;
    logic          amo_valid = 1'b0, amo_done;
    logic [AW-1:0] amo_addr = '0;
    logic [DW-1:0] amo_wdata = '0, amo_rdata;
    logic          buffer_empty, mem_req;
    logic [1:0]    mem_op;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_gnt;
    logic          mem_rvalid = 1'b0;
    logic [DW-1:0] mem_rdata = '0;

    tso_wbuf #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) i_tso_wbuf (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr), .st_data(st_data),
        .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_done(ld_done), .ld_rdata(ld_rdata),
        .fence_req(fence_req), .fence_done(fence_done),
        .amo_valid(amo_valid), .amo_addr(amo_addr), .amo_wdata(amo_wdata),
        .amo_done(amo_done), .amo_rdata(amo_rdata),
        .buffer_empty(buffer_empty),
        .mem_req(mem_req), .mem_op(mem_op), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] ref_mem [NW];
    logic [DW-1:0] phys [NW];
    logic [AW+DW-1:0] exp_w [$];
    logic [AW+DW-1:0] wlog [$];
    logic [DW-1:0] exp_ld [$];
    bit exp_fwd [$];
    string exp_tag [$];
    int  n_writes = 0;
    int  st_count = 0;
    int  ld_seen = 0;
    bit  swap_clean = 1'b0;
    bit  last_ld_empty = 1'b0;
    int  last_ld_writes = 0;
    logic gnt_en = 1'b1;
    bit  rnd_gnt = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    assign mem_gnt = gnt_en;

    function automatic logic [DW-1:0] init_word(input int i);
        return DW'(i * 37 + 16'h0100);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Memory responder: one-cycle read latency, writes complete on grant.
    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (!rst_n) begin
            for (int i = 0; i < NW; i++) phys[i] <= init_word(i);
        end else if (mem_req && mem_gnt) begin
            case (mem_op)
                2'd1: begin
                    phys[mem_addr] <= mem_wdata;
                    wlog.push_back({mem_addr, mem_wdata});
                    n_writes++;
                end
                2'd0: begin
                    mem_rdata  <= phys[mem_addr];
                    mem_rvalid <= 1'b1;
                end
                2'd2: begin
                    mem_rdata      <= phys[mem_addr];
                    phys[mem_addr] <= mem_wdata;
                    mem_rvalid     <= 1'b1;
                    swap_clean     = (exp_w.size() == 0);
                end
                default: ;
            endcase
        end
    end

    // Pseudo-random grant stalls.
    always @(posedge clk) begin
        #1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (rnd_gnt) gnt_en = lfsr[0] | lfsr[3];
    end

    // Monitor: write order scoreboard (R3).
    always @(negedge clk) begin
        while (wlog.size() > 0) begin
            logic [AW+DW-1:0] w, e;
            w = wlog.pop_front();
            if (exp_w.size() == 0) begin
                chk(1'b0, "R3 unexpected write", int'(w), 0);
            end else begin
                e = exp_w.pop_front();
                chk(w == e, "R3 write order", int'(w), int'(e));
            end
        end
    end

    // Monitor: load result scoreboard (R4, R5).
    always @(negedge clk) begin
        if (ld_done) begin
            logic [DW-1:0] e;
            bit f;
            string t;
            e = exp_ld.pop_front();
            f = exp_fwd.pop_front();
            t = exp_tag.pop_front();
            chk(ld_rdata == e, t, int'(ld_rdata), int'(e));
            if (f) chk(!(mem_req && mem_op == 2'd0), "R4 no read on hit", int'(mem_op), 1);
            last_ld_empty  = buffer_empty;
            last_ld_writes = n_writes;
            ld_seen++;
        end
    end

    task automatic do_store(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(posedge clk); #1;
        st_valid = 1'b1; st_addr = a; st_data = d;
        @(negedge clk);
        while (!st_ready) @(negedge clk);
        @(posedge clk);
        ref_mem[a] = d;
        exp_w.push_back({a, d});
        st_count++;
        #1 st_valid = 1'b0;
    endtask

    task automatic do_load(input logic [AW-1:0] a, input bit fwd, input bit open_gnt, input string tag);
        int target;
        exp_ld.push_back(ref_mem[a]);
        exp_fwd.push_back(fwd);
        exp_tag.push_back(tag);
        target = ld_seen + 1;
        @(posedge clk); #1;
        ld_valid = 1'b1; ld_addr = a;
        if (open_gnt) gnt_en = 1'b1;
        wait (ld_seen == target);
        @(posedge clk); #1 ld_valid = 1'b0;
    endtask

    task automatic do_fence(input bit open_gnt);
        @(posedge clk); #1;
        fence_req = 1'b1;
        if (open_gnt) gnt_en = 1'b1;
        @(negedge clk);
        while (!fence_done) @(negedge clk);
        chk(buffer_empty == 1'b1, "R6 empty at fence_done", int'(buffer_empty), 1);
        chk(n_writes == st_count, "R6 older stores written", n_writes, st_count);
        chk(st_ready == 1'b0, "R6 stores held during fence", int'(st_ready), 0);
        @(posedge clk); #1 fence_req = 1'b0;
        @(negedge clk);
        chk(fence_done == 1'b0, "R6 single-cycle pulse", int'(fence_done), 0);
    endtask

    task automatic do_amo(input logic [AW-1:0] a, input logic [DW-1:0] wd, input bit open_gnt);
        logic [DW-1:0] e;
        e = ref_mem[a];
        ref_mem[a] = wd;
        @(posedge clk); #1;
        amo_valid = 1'b1; amo_addr = a; amo_wdata = wd;
        if (open_gnt) gnt_en = 1'b1;
        @(negedge clk);
        while (!amo_done) @(negedge clk);
        chk(amo_rdata == e, "R7 swap old value", int'(amo_rdata), int'(e));
        chk(swap_clean, "R7 swap after drain", int'(swap_clean), 1);
        chk(n_writes == st_count, "R7 older stores written", n_writes, st_count);
        @(posedge clk); #1 amo_valid = 1'b0;
    endtask

    initial begin
        int unsigned seed;
        for (int i = 0; i < NW; i++) ref_mem[i] = init_word(i);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(mem_req == 1'b0, "R9 no request in reset", int'(mem_req), 0);
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        chk(buffer_empty == 1'b1, "R9 empty after reset", int'(buffer_empty), 1);
        chk(st_ready == 1'b1, "R9 R1 ready after reset", int'(st_ready), 1);
        chk(mem_req == 1'b0, "R9 idle memory port", int'(mem_req), 0);
        chk(fence_done == 1'b0 && amo_done == 1'b0, "R9 no done pulses", int'(fence_done), 0);

        // Miss on an empty queue reads memory.
        do_load(4'd7, 1'b0, 1'b0, "R5 miss read");

        // Forwarding: youngest of two matching stores wins.
        gnt_en = 1'b0;
        do_store(4'd5, 16'hAAAA);
        do_store(4'd5, 16'hBBBB);
        @(negedge clk);
        chk(buffer_empty == 1'b0, "R8 not empty with stores", int'(buffer_empty), 0);
        chk(st_ready == 1'b1, "R1 ready below capacity", int'(st_ready), 1);
        do_load(4'd5, 1'b1, 1'b0, "R4 youngest forward");

        // Bypass: a missing load goes ahead of queued stores.
        do_store(4'd2, 16'h1234);
        do_load(4'd9, 1'b0, 1'b1, "R5 bypass read");
        chk(last_ld_empty == 1'b0, "R5 load done with stores queued", int'(last_ld_empty), 0);
        chk(last_ld_writes == 0, "R5 read before drain", last_ld_writes, 0);
        do_fence(1'b1);
        do_load(4'd5, 1'b0, 1'b0, "R3 drained value in memory");

        // Capacity.
        gnt_en = 1'b0;
        do_store(4'd1, 16'h0011);
        do_store(4'd3, 16'h0033);
        do_store(4'd1, 16'h0111);
        do_store(4'd4, 16'h0044);
        @(negedge clk);
        chk(st_ready == 1'b0, "R2 full blocks stores", int'(st_ready), 0);
        do_load(4'd1, 1'b1, 1'b0, "R4 forward from full queue");
        do_fence(1'b1);

        // Fence on an empty queue.
        do_fence(1'b0);

        // Atomic swap with stores pending.
        gnt_en = 1'b0;
        do_store(4'd3, 16'h3333);
        do_store(4'd6, 16'h6666);
        do_amo(4'd3, 16'hC0DE, 1'b1);
        do_load(4'd3, 1'b0, 1'b0, "R7 swap wrote memory");

        // Mixed traffic under grant stalls.
        rnd_gnt = 1'b1;
        seed = 32'd12345;
        for (int n = 0; n < 120; n++) begin
            logic [AW-1:0] a;
            seed = seed * 32'd1103515245 + 32'd12345;
            a = AW'((seed >> 8) & 32'h7);
            case ((seed >> 16) % 8)
                0, 1, 2: do_store(a, DW'(seed >> 4));
                3, 4:    do_load(a, 1'b0, 1'b0, "R5 mixed load");
                5:       do_store(a + 4'd8, DW'(seed >> 3));
                6:       do_fence(1'b0);
                default: do_amo(a, DW'(seed >> 5), 1'b0);
            endcase
        end
        rnd_gnt = 1'b0;
        @(posedge clk); #1 gnt_en = 1'b1;
        do_fence(1'b0);
        @(negedge clk);
        for (int i = 0; i < NW; i++)
            chk(phys[i] == ref_mem[i], "R3 final memory image", int'(phys[i]), int'(ref_mem[i]));
        chk(exp_w.size() == 0, "R3 all stores written", exp_w.size(), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule